// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This block watches a two-wire serial bus from the slave side. It brings the clock and data lines into the local clock domain through flop chains, then detects start and stop conditions and the clock edges. After each start or repeated start it shifts in the first byte, most significant bit first. In recognition mode it compares the upper seven bits with a programmable own address and also accepts the all-zero general-call byte. On acceptance it pulls the data line low for the ninth (acknowledge) clock and reports whether the slave should transmit or receive.

A mode input selects free data format. In that mode the first byte is taken as data and is always acknowledged. A no-acknowledge control keeps the slave off the bus in recognition mode, for both a matching address and a general call. The own address and mode can be written only while the bus is idle. The first byte is shown on a one-cycle strobe with no back-pressure, because the bus cannot be held here (clock stretching is not part of this block). Configuration and status pins are plain levels.

Top module: `i2c_addr_recog`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A stop or a repeated start clears `addressed_o`, `gcall_o`, `dir_tx_o` and `sda_pull_o`.
- R2: After each start, the eight bits of the first byte are sampled on clock rising edges, most significant bit first. Once the eighth bit is in, `byte_valid_o` pulses for one cycle with the byte on `byte_data_o`. No other byte raises the pulse.
- R3: When the first byte is accepted, `sda_pull_o` (1 = pull the data line low) rises after the clock falling edge that ends bit 8 and falls after the clock falling edge that ends bit 9. `addressed_o` rises together with it.
- R4: In recognition mode, a byte whose upper seven bits equal the own address is accepted. Bit 0 of that byte (1 = read) is copied to `dir_tx_o` (1 = slave transmits).
- R5: A first byte that is not accepted leaves the data line released and `addressed_o` low. All later traffic is then ignored until the next stop or repeated start.
- R6: In recognition mode, the byte 0x00 is accepted as a general call whatever the own address is. It sets `gcall_o` and leaves `dir_tx_o` at 0.
- R7: In recognition mode with `cfg_nack_i` = 1, no first byte is accepted, neither a matching address nor a general call.
- R8: With free mode = 1, any first byte is accepted as received data with `dir_tx_o` = 0 and `gcall_o` = 0, whatever `cfg_nack_i` is.
- R9: A `cfg_wr_i` strobe loads the own address and the free-mode bit only while the bus is idle (from reset or a stop until the next start). A strobe during a transfer has no effect.
- R10: After reset the own address is 0 and recognition mode is selected, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = drive the data line low (open drain) |
| cfg_wr_i | input | 1 | Configuration load strobe |
| cfg_addr_i | input | 7 | Own address to load |
| cfg_free_i | input | 1 | Free-mode bit to load (1 = free data format) |
| cfg_nack_i | input | 1 | 1 = never acknowledge in recognition mode |
| addressed_o | output | 1 | Slave selected for the current transfer |
| dir_tx_o | output | 1 | 1 = slave transmits, 0 = slave receives |
| gcall_o | output | 1 | Selected through a general call |
| byte_valid_o | output | 1 | One-cycle strobe for the first byte |
| byte_data_o | output | 8 | First byte after the start |

## Verification
A wrong bit count or a wrong shift order shows up on the strobe of the same byte, as a value that differs from the one driven. It also shows on the data line as an acknowledge missing or arriving one bit early. A decision state that does not return to idle shows up at the next transfer, either as configuration writes that have no effect or as a byte that is ignored. An ignore state that does not end at a stop or repeated start gives a missing acknowledge on the very next addressed byte.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_ACTIVE,
    ST_IGNORE
  } ar_state_e;
endpackage

// File: rtl/i2c_ar_sync.sv
module i2c_ar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [1:0] chain [STAGES];
  logic       scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 2'b11;
        else        chain[g] <= {scl_i, sda_i};
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 2'b11;
        else        chain[g] <= chain[g-1];
    end
  end

  logic scl_s, sda_s;
  assign scl_s = chain[STAGES-1][1];
  assign sda_s = chain[STAGES-1][0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign sda_o      = sda_s;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
endmodule

// File: rtl/i2c_ar_shift.sv
module i2c_ar_shift #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         last_o,
  output logic         full_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      data_o <= '0;
    end else if (clr_i) begin
      cnt <= '0;
    end else if (shift_i && !full_o) begin
      cnt    <= cnt + 1'b1;
      data_o <= {data_o[W-2:0], bit_i};
    end

  assign last_o = (cnt == CW'(W - 1));
  assign full_o = (cnt == CW'(W));
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import i2c_ar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_free_i,
  input  logic              cfg_nack_i,
  output logic              addressed_o,
  output logic              dir_tx_o,
  output logic              gcall_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o
);
  ar_state_e         state;
  logic              sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic              last_bit, byte_full, shift_en;
  logic [ADDR_W-1:0] own_addr;
  logic              free_mode;
  logic              bus_idle;
  logic              is_gcall, is_match, accept;

  i2c_ar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .start_o(start_det), .stop_o(stop_det),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  assign shift_en = (state == ST_ADDR) && scl_rise;

  i2c_ar_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr_i(start_det), .shift_i(shift_en),
    .bit_i(sda_s), .data_o(byte_data_o), .last_o(last_bit),
    .full_o(byte_full)
  );

  assign bus_idle = (state == ST_IDLE);

  // configuration is only taken between a stop (or reset) and the next start
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      own_addr  <= '0;
      free_mode <= 1'b0;
    end else if (cfg_wr_i && bus_idle) begin
      own_addr  <= cfg_addr_i;
      free_mode <= cfg_free_i;
    end

  assign is_gcall = (byte_data_o == '0);
  assign is_match = (byte_data_o[BYTE_W-1:1] == own_addr);
  assign accept   = free_mode | (~cfg_nack_i & (is_gcall | is_match));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state        <= ST_IDLE;
      sda_pull_o   <= 1'b0;
      addressed_o  <= 1'b0;
      dir_tx_o     <= 1'b0;
      gcall_o      <= 1'b0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      if (start_det || stop_det) begin
        state       <= start_det ? ST_ADDR : ST_IDLE;
        sda_pull_o  <= 1'b0;
        addressed_o <= 1'b0;
        dir_tx_o    <= 1'b0;
        gcall_o     <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (shift_en && last_bit) byte_valid_o <= 1'b1;
            if (scl_fall && byte_full) begin
              if (accept) begin
                state       <= ST_ACK;
                sda_pull_o  <= 1'b1;
                addressed_o <= 1'b1;
                gcall_o     <= ~free_mode & is_gcall;
                dir_tx_o    <= ~free_mode & ~is_gcall & byte_data_o[0];
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state      <= ST_ACTIVE;
              sda_pull_o <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/i2c_ar_checker.sv
module i2c_ar_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_det,
  input logic       stop_det,
  input logic       bus_idle,
  input logic [6:0] own_addr,
  input logic       free_mode,
  input logic       sda_pull_o,
  input logic       addressed_o,
  input logic       dir_tx_o,
  input logic       gcall_o,
  input logic       byte_valid_o
);
  a_r1_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !addressed_o && !sda_pull_o && !gcall_o);
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !addressed_o && !sda_pull_o && !dir_tx_o);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o);
  a_r3_pull_with_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed_o) |-> sda_pull_o);
  a_r3_pull_implies_select: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> addressed_o);
  a_r6_gcall_receives: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_o |-> addressed_o && !dir_tx_o);
  a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> $stable(own_addr) && $stable(free_mode));
endmodule

bind i2c_addr_recog i2c_ar_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .bus_idle(bus_idle), .own_addr(own_addr), .free_mode(free_mode),
  .sda_pull_o(sda_pull_o), .addressed_o(addressed_o), .dir_tx_o(dir_tx_o),
  .gcall_o(gcall_o), .byte_valid_o(byte_valid_o)
);

// File: tb/i2c_addr_recog_bench.sv
module i2c_addr_recog_bench;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       cfg_wr = 1'b0, cfg_free = 1'b0, cfg_nack = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic       sda_pull, addressed, dir_tx, gcall, byte_valid;
  logic [7:0] byte_data;
  logic       sda_line;
  int         errors = 0, checks = 0;
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_addr_recog u_i2c_addr_recog (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_free_i(cfg_free), .cfg_nack_i(cfg_nack), .addressed_o(addressed),
    .dir_tx_o(dir_tx), .gcall_o(gcall), .byte_valid_o(byte_valid),
    .byte_data_o(byte_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && byte_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected strobe: actual=%0h expected=none", byte_data);
      end else begin
        check(int'(byte_data), int'(exp_q.pop_front()), "R2 first byte");
      end
    end
  end

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit first,
                           input int exp_ack, input string tag);
    if (first) exp_q.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q / 2);
    check(int'(!sda_line), exp_ack, tag);
    tick(Q / 2);
    m_scl = 1'b0; tick(Q);
    check(int'(sda_pull), 0, "R3 released after 9th clock");
  endtask

  task automatic cfg_write(input logic [6:0] a, input logic f);
    cfg_addr = a; cfg_free = f; cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
    tick(1);
  endtask

  initial begin
    tick(5);
    check(int'(sda_pull), 0, "R10 reset pull");
    check(int'(addressed), 0, "R10 reset addressed");
    check(int'(byte_valid), 0, "R10 reset strobe");
    rst_n = 1'b1;
    tick(5);

    // R10: own address 0 after reset, recognition mode; read bit set
    bus_start();
    send_byte(8'h01, 1, 1, "R10 reset address 0 acked");
    check(int'(addressed), 1, "R4 addressed");
    check(int'(dir_tx), 1, "R4 read sets transmit");
    bus_stop();
    check(int'(addressed), 0, "R1 stop clears addressed");

    // R4 write direction, R9 write during transfer ignored
    cfg_write(7'h5A, 1'b0);
    bus_start();
    send_byte(8'hB4, 1, 1, "R4 match write acked");
    check(int'(dir_tx), 0, "R4 write sets receive");
    check(int'(gcall), 0, "R4 no general call");
    cfg_addr = 7'h11; cfg_free = 1'b1; cfg_wr = 1'b1; tick(1); cfg_wr = 1'b0;
    bus_start();
    check(int'(addressed), 0, "R1 repeated start clears addressed");
    send_byte(8'hB5, 1, 1, "R4 match read acked");
    check(int'(dir_tx), 1, "R4 read direction");
    bus_stop();

    bus_start();
    send_byte(8'h22, 1, 0, "R9 busy write not taken");
    bus_stop();
    bus_start();
    send_byte(8'hB4, 1, 1, "R9 old address kept");
    bus_stop();

    // R5 mismatch, then ignore until repeated start
    bus_start();
    send_byte(8'hB6, 1, 0, "R5 mismatch not acked");
    check(int'(addressed), 0, "R5 not addressed");
    send_byte(8'hB4, 0, 0, "R5 later traffic ignored");
    check(int'(addressed), 0, "R5 still not addressed");
    bus_start();
    send_byte(8'hB4, 1, 1, "R5 repeated start resumes");
    bus_stop();

    // R6 general call
    bus_start();
    send_byte(8'h00, 1, 1, "R6 general call acked");
    check(int'(gcall), 1, "R6 general call flag");
    check(int'(dir_tx), 0, "R6 general call receives");
    bus_stop();
    check(int'(gcall), 0, "R1 stop clears general call");

    // R7 no-acknowledge control
    cfg_nack = 1'b1;
    bus_start();
    send_byte(8'hB4, 1, 0, "R7 match blocked");
    check(int'(addressed), 0, "R7 not addressed");
    bus_stop();
    bus_start();
    send_byte(8'h00, 1, 0, "R7 general call blocked");
    check(int'(gcall), 0, "R7 no general call flag");
    bus_stop();

    // R8 free data format ignores nack and address
    cfg_write(7'h5A, 1'b1);
    bus_start();
    send_byte(8'h37, 1, 1, "R8 free byte acked");
    check(int'(addressed), 1, "R8 addressed");
    check(int'(dir_tx), 0, "R8 receives");
    check(int'(gcall), 0, "R8 no general call");
    bus_stop();
    cfg_nack = 1'b0;
    tick(20);

    check(exp_q.size(), 0, "R2 all first bytes seen");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule